// File: doc/BRIEF.md
# Branch-Resolving Fetch Controller

This block owns the program counter and the fetch-to-decode handoff of a five-stage in-order pipeline (fetch, decode, execute, memory, write-back). Each cycle it presents a fetch address to instruction memory and takes the returned word combinationally. On the next edge it moves that word, with its address, into the decode stage and marks it valid. Fetching is always sequential until the decode stage reports a taken branch and gives its target. The controller then sends the following fetch to the target on the next edge.

A compile-time parameter picks what happens to the word fetched behind a taken branch. In the squashing variant that word is killed, and decode sees a bubble in its place. In the single-slot variant that word always goes on to decode as a valid instruction. A taken-branch report made while the delay-slot instruction sits in decode is then disregarded. A stall input freezes the program counter and the decode stage. A redirect requested during a stall waits and takes effect in the first cycle without stall.

Top module: `branch_fetch_unit`

## Requirements
- R1: While reset is held, and on the first cycle after it is released, `fetchAddr` equals `RESET_ADDR` and `decValid` is 0.
- R2: In a cycle with `stall` low and no redirect, the next cycle shows `fetchAddr` advanced by `ADDR_STEP`. The same edge loads `decInstr` and `decPc` with the word and address that were being fetched, and sets `decValid` to 1.
- R3: A redirect happens in a cycle where `stall` is low, `decTaken` is 1, `decValid` is 1 and (single-slot variant only) the decode word is not a delay slot. On the next cycle `fetchAddr` equals the `decTarget` of that cycle. `decTaken` has no effect while `decValid` is 0.
- R4: Squashing variant (`DELAY_SLOT`=0): `fetchKill` is 1 exactly in redirect cycles. On the following cycle `decValid` is 0.
- R5: Single-slot variant (`DELAY_SLOT`=1): `fetchKill` is always 0. The word fetched in a redirect cycle arrives in decode on the next cycle with `decValid` 1.
- R6: Single-slot variant: the decode word that entered on the edge closing a redirect cycle is a delay slot. A `decTaken` report while it is in decode causes no redirect, and fetching stays sequential.
- R7: While `stall` is 1, `fetchAddr`, `decInstr`, `decPc` and `decValid` keep their values, and `fetchKill` is 0, even when `decTaken` is 1.
- R8: A taken branch held in decode across a stall redirects in the first cycle with `stall` low. The next cycle shows `fetchAddr` equal to that cycle's `decTarget`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Active-low synchronous reset |
| stall | input | 1 | Freezes program counter and decode stage |
| fetchInstr | input | INSTR_W | Word returned for the current fetch address |
| decTaken | input | 1 | Decode stage reports a taken branch |
| decTarget | input | ADDR_W | Branch target that goes with decTaken |
| fetchAddr | output | ADDR_W | Address being fetched this cycle |
| fetchKill | output | 1 | Word being fetched this cycle is discarded |
| decInstr | output | INSTR_W | Instruction held in decode |
| decPc | output | ADDR_W | Address of the instruction held in decode |
| decValid | output | 1 | Decode instruction is live |

## Verification
Most errors in this block surface within one or two cycles at the ports. A wrong delay-slot flag lets a slot branch redirect, or blocks a genuine branch, and the next cycle shows a target address where a sequential one is expected, or the reverse. A kill or valid bit stuck at the wrong value appears as a bubble in decode, or as a squashed word marked live, one edge after the redirect. A stall that leaks lets `fetchAddr` or `decPc` change while stall is high. Both variants run side by side from the same stimulus. Each is compared every cycle against a behavioural model of the requirements.

// File: rtl/fetch_unit_pkg.sv
package fetch_unit_pkg;
  // Strobes from control to datapath for one cycle.
  typedef struct packed {
    logic advance;   // pipeline moves on this edge
    logic redirect;  // program counter takes the branch target
  } fetchStrobe_t;
endpackage

// File: rtl/fetch_unit_ctrl.sv
module fetch_unit_ctrl
  import fetch_unit_pkg::*;
#(
  parameter bit DELAY_SLOT = 1'b0
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         stall,
  input  logic         decTaken,
  output fetchStrobe_t strobe,
  output logic         fetchKill,
  output logic         decValid
);
  logic validQ;
  logic slotQ;
  logic redirReq;
  logic validD;
  logic slotD;

  generate
    if (DELAY_SLOT) begin : g_slot
      // a branch sitting in the delay slot never redirects
      assign redirReq  = decTaken && validQ && !slotQ;
      assign fetchKill = 1'b0;
      assign validD    = 1'b1;
      assign slotD     = strobe.redirect;
    end else begin : g_flush
      assign redirReq  = decTaken && validQ;
      assign fetchKill = strobe.redirect;
      assign validD    = !strobe.redirect;
      assign slotD     = 1'b0;
    end
  endgenerate

  always_comb begin
    strobe.advance  = !stall;
    strobe.redirect = redirReq && !stall;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validQ <= 1'b0;
      slotQ  <= 1'b0;
    end else if (strobe.advance) begin
      validQ <= validD;
      slotQ  <= slotD;
    end
  end

  assign decValid = validQ;

  // R7
  stall_hold_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    stall |=> $stable(decValid));

  // R7
  stall_no_kill_chk: assert property (@(posedge clk) disable iff (!rstN)
    stall |-> !fetchKill);

  generate
    if (DELAY_SLOT) begin : g_slot_chk
      // R5
      slot_live_chk: assert property (@(posedge clk) disable iff (!rstN)
        strobe.redirect |=> decValid);
      // R6
      slot_no_redirect_chk: assert property (@(posedge clk) disable iff (!rstN)
        strobe.redirect |=> !strobe.redirect);
    end else begin : g_flush_chk
      // R4
      flush_bubble_chk: assert property (@(posedge clk) disable iff (!rstN)
        fetchKill |=> !decValid);
    end
  endgenerate
endmodule

// File: rtl/fetch_unit_dp.sv
module fetch_unit_dp
  import fetch_unit_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int INSTR_W    = 32,
  parameter int RESET_ADDR = 0,
  parameter int ADDR_STEP  = 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  fetchStrobe_t       strobe,
  input  logic [INSTR_W-1:0] fetchInstr,
  input  logic [ADDR_W-1:0]  decTarget,
  output logic [ADDR_W-1:0]  fetchAddr,
  output logic [INSTR_W-1:0] decInstr,
  output logic [ADDR_W-1:0]  decPc
);
  localparam logic [ADDR_W-1:0] RST_V  = ADDR_W'(RESET_ADDR);
  localparam logic [ADDR_W-1:0] STEP_V = ADDR_W'(ADDR_STEP);

  logic [ADDR_W-1:0]  pcQ;
  logic [ADDR_W-1:0]  pcD;
  logic [INSTR_W-1:0] instrQ;
  logic [ADDR_W-1:0]  decPcQ;

  always_comb begin
    if (strobe.redirect)     pcD = decTarget;
    else if (strobe.advance) pcD = pcQ + STEP_V;
    else                     pcD = pcQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pcQ    <= RST_V;
      instrQ <= '0;
      decPcQ <= RST_V;
    end else begin
      pcQ <= pcD;
      if (strobe.advance) begin
        instrQ <= fetchInstr;
        decPcQ <= pcQ;
      end
    end
  end

  assign fetchAddr = pcQ;
  assign decInstr  = instrQ;
  assign decPc     = decPcQ;

  // R2
  seq_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.advance && !strobe.redirect) |=> fetchAddr == $past(fetchAddr) + STEP_V);

  // R3
  target_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.redirect |=> fetchAddr == $past(decTarget));

  // R7
  stall_hold_pc_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.advance |=> $stable(fetchAddr) && $stable(decPc) && $stable(decInstr));
endmodule

// File: rtl/branch_fetch_unit.sv
module branch_fetch_unit
  import fetch_unit_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int INSTR_W    = 32,
  parameter int RESET_ADDR = 0,
  parameter int ADDR_STEP  = 1,
  parameter bit DELAY_SLOT = 1'b0
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               stall,
  input  logic [INSTR_W-1:0] fetchInstr,
  input  logic               decTaken,
  input  logic [ADDR_W-1:0]  decTarget,
  output logic [ADDR_W-1:0]  fetchAddr,
  output logic               fetchKill,
  output logic [INSTR_W-1:0] decInstr,
  output logic [ADDR_W-1:0]  decPc,
  output logic               decValid
);
  fetchStrobe_t strobe;

  fetch_unit_ctrl #(.DELAY_SLOT(DELAY_SLOT)) u_ctrl (
    .clk(clk), .rstN(rstN), .stall(stall), .decTaken(decTaken),
    .strobe(strobe), .fetchKill(fetchKill), .decValid(decValid)
  );

  fetch_unit_dp #(
    .ADDR_W(ADDR_W), .INSTR_W(INSTR_W),
    .RESET_ADDR(RESET_ADDR), .ADDR_STEP(ADDR_STEP)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .fetchInstr(fetchInstr),
    .decTarget(decTarget), .fetchAddr(fetchAddr), .decInstr(decInstr),
    .decPc(decPc)
  );

  // R1
  reset_addr_chk: assert property (@(posedge clk)
    !rstN |=> fetchAddr == ADDR_W'(RESET_ADDR) && !decValid);
endmodule

// File: tb/branch_fetch_unit_bench.sv
module branch_fetch_unit_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;
  localparam int IW = 32;
  localparam int RST = 'h100;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic stall = 1'b0;
  logic decTaken = 1'b0;
  logic [AW-1:0] decTarget = '0;
  int checks = 0;
  int errors = 0;

  logic [AW-1:0] fAddr[2];
  logic          fKill[2];
  logic [IW-1:0] dInstr[2];
  logic [AW-1:0] dPc[2];
  logic          dValid[2];
  logic [IW-1:0] fInstr[2];

  // model state, index 0 = squashing, 1 = single slot
  logic [AW-1:0] mPc[2];
  logic [IW-1:0] mInstr[2];
  logic [AW-1:0] mDecPc[2];
  logic          mValid[2];
  logic          mSlot[2];

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [IW-1:0] instrOf(input logic [AW-1:0] a);
    return {a ^ 16'hA5C3, ~a};
  endfunction

  assign fInstr[0] = instrOf(fAddr[0]);
  assign fInstr[1] = instrOf(fAddr[1]);

  branch_fetch_unit #(.ADDR_W(AW), .INSTR_W(IW), .RESET_ADDR(RST), .DELAY_SLOT(1'b0))
  u_branch_fetch_unit (
    .clk(clk), .rstN(rstN), .stall(stall), .fetchInstr(fInstr[0]),
    .decTaken(decTaken), .decTarget(decTarget), .fetchAddr(fAddr[0]),
    .fetchKill(fKill[0]), .decInstr(dInstr[0]), .decPc(dPc[0]), .decValid(dValid[0])
  );

  branch_fetch_unit #(.ADDR_W(AW), .INSTR_W(IW), .RESET_ADDR(RST), .DELAY_SLOT(1'b1))
  u_branch_fetch_unit_slot (
    .clk(clk), .rstN(rstN), .stall(stall), .fetchInstr(fInstr[1]),
    .decTaken(decTaken), .decTarget(decTarget), .fetchAddr(fAddr[1]),
    .fetchKill(fKill[1]), .decInstr(dInstr[1]), .decPc(dPc[1]), .decValid(dValid[1])
  );

  task automatic check(input string tag, input int m, input string what,
                       input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s mode%0d %s: actual %0h expected %0h", tag, m, what, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic checkRegs(input string tag);
    for (int m = 0; m < 2; m++) begin
      check(tag, m, "fetchAddr", fAddr[m], mPc[m]);
      check(tag, m, "decValid", dValid[m], mValid[m]);
      check(tag, m, "decPc", dPc[m], mDecPc[m]);
      check(tag, m, "decInstr", dInstr[m], mInstr[m]);
    end
  endtask

  // one cycle: starts and ends on a falling edge
  task automatic step(input logic s, input logic t, input logic [AW-1:0] tgt,
                      input string tag);
    checkRegs(tag);
    stall = s; decTaken = t; decTarget = tgt;
    #1;
    for (int m = 0; m < 2; m++) begin
      logic redir;
      redir = t && mValid[m] && !(m == 1 && mSlot[m]) && !s;
      check(m == 0 ? "R4/R7" : "R5/R7", m, "fetchKill", fKill[m], (m == 0) && redir);
      if (!s) begin
        mInstr[m] = instrOf(mPc[m]);
        mDecPc[m] = mPc[m];
        mValid[m] = !((m == 0) && redir);
        mSlot[m]  = (m == 1) && redir;
        mPc[m]    = redir ? tgt : mPc[m] + AW'(1);
      end
    end
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual running expected done");
    finishRun();
  end

  initial begin
    void'($urandom(32'h1F2E3D4C));
    for (int m = 0; m < 2; m++) begin
      mPc[m] = AW'(RST); mInstr[m] = '0; mDecPc[m] = AW'(RST);
      mValid[m] = 1'b0; mSlot[m] = 1'b0;
    end
    repeat (3) @(negedge clk);
    checkRegs("R1");
    rstN = 1'b1;
    checkRegs("R1");
    // taken report while decode invalid is ignored
    step(0, 1, 16'h0500, "R1");
    step(0, 0, 16'h0000, "R3");
    step(0, 0, 16'h0000, "R2");
    // taken branch, then a branch in the slot (ignored in slot mode)
    step(0, 1, 16'h0040, "R2");
    step(0, 1, 16'h0080, "R4/R5");
    step(0, 0, 16'h0000, "R6");
    step(0, 0, 16'h0000, "R3");
    // stall with a taken branch held in decode, then release
    step(1, 1, 16'h0020, "R2");
    step(1, 1, 16'h0020, "R7");
    step(0, 1, 16'h0020, "R7");
    step(0, 0, 16'h0000, "R8");
    // back-to-back taken reports without stall
    step(0, 1, 16'h0300, "R3");
    step(0, 1, 16'h0310, "R4/R6");
    step(0, 1, 16'h0320, "R3/R6");
    step(0, 0, 16'h0000, "R3");
    // random mix
    for (int i = 0; i < 4000; i++) begin
      logic s, t;
      s = ($urandom % 5) == 0;
      t = ($urandom % 10) < 3;
      step(s, t, AW'($urandom), "R2/R3/R7");
    end
    checkRegs("R2");
    finishRun();
  end
endmodule